// File: doc/BRIEF.md
# Deskew Lane Reference Frame Generator

This block produces the serial bit stream for a side lane that travels next to ten parallel data lanes. Every data lane moves 68-bit units, each a 64-bit data word with a 4-bit control word. Two consecutive units on a lane form one 136-bit period. For every period the block emits one 136-bit reference frame. A receiver can use the frame to measure how far each data lane has slipped against the others.

Each frame contains four framing bytes, then one byte sampled from every data lane, then a 24-bit CRC. The sampled bytes are taken at the same point of the period on all lanes. The receive side finds the framing pattern on the side lane, then searches each data lane for its own sampled byte to find that lane's offset.

Units enter as one beat per unit on a valid/ready input that carries all lanes side by side. A beat transfers on a clock edge where `in_valid` and `in_ready` are both high. The frame leaves one bit per transfer on a valid/ready output, most significant bit first. A start marker travels with the first bit of each frame. Either side may stall. While `out_ready` is low, the current bit and its marker stay frozen. While a finished frame cannot yet be handed to the serializer, the second unit of the next pair is refused.

Top module: `dsk_refgen`

## Requirements
- R1: Every frame is exactly 136 output transfers long. `out_sof` is high on the first transfer of a frame and low on the other 135.
- R2: Frame bits 135..104 are the framing bytes 0xF6, 0xF6, 0x28, 0x28, in that order.
- R3: Frame bits 103..24 hold ten sample bytes, lane 0 first. The sample for lane n is bits [67:60] of lane n's slot, `in_data[68n+67:68n]`, taken from the first unit of the pair.
- R4: Frame bits 23..0 are a CRC over frame bits 135..24, fed most significant bit first. The CRC uses polynomial 0x864CFB, starts from 0xFFFFFF and has no final inversion.
- R5: After reset the first accepted unit opens a pair and accepted units then alternate first/second. The contents of the second unit do not affect the frame.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_sof` hold their values into the next cycle.
- R7: `in_ready` is high whenever the next unit opens a pair. For the second unit of a pair, `in_ready` is low only while a completed frame is waiting and the serializer is not taking it in that cycle.
- R8: When a completed frame is waiting as the last bit of the current frame transfers, the waiting frame's first bit is valid in the very next cycle, with no gap.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A unit for all lanes is offered |
| in_ready | output | 1 | The offered unit is taken at this edge |
| in_data | input | 680 | Ten 68-bit lane units; lane n in bits [68n+67:68n] |
| out_valid | output | 1 | `out_bit` is valid |
| out_ready | input | 1 | The sink takes `out_bit` at this edge |
| out_bit | output | 1 | Serial frame bit, most significant first |
| out_sof | output | 1 | High on the first bit of a frame |

## Verification
A pair-phase counter that is wrong by one swaps which unit is sampled. That shows up in the sample bytes of the very first frame, and the CRC field of the same frame disagrees as well. A bit counter or CRC register that is corrupted spoils the framing bytes or the trailing 24 bits within one frame, about 136 transfers. A slot flag that is wrong shows within one pair time: either `in_ready` stays high when the slot is full, or a one-cycle gap appears between frames.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int UNIT_W  = 68;
  localparam int SAMP_W  = 8;
  localparam int HDR_W   = 32;
  localparam int CRC_W   = 24;
  localparam logic [7:0] FRM_A1 = 8'hF6;
  localparam logic [7:0] FRM_A2 = 8'h28;
  localparam logic [CRC_W-1:0] CRC_POLY = 24'h864CFB;
  localparam logic [CRC_W-1:0] CRC_SEED = 24'hFFFFFF;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/dsk_sampler.sv
module dsk_sampler
  import dsk_pkg::*;
#(
  parameter int LANES = 10,
  localparam int PAY_W = HDR_W + LANES * SAMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*UNIT_W-1:0] in_data,
  output logic                    pend_valid,
  input  logic                    pend_ready,
  output logic [PAY_W-1:0]        pend_payload
);
  logic                      second_q;
  logic                      slot_full;
  logic [LANES*SAMP_W-1:0]   samp_d, samp_q;
  logic [PAY_W-1:0]          slot_q;
  logic                      take;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign samp_d[(LANES-1-n)*SAMP_W +: SAMP_W] = in_data[n*UNIT_W + UNIT_W - SAMP_W +: SAMP_W];
  end

  assign in_ready     = !second_q || !slot_full || pend_ready;
  assign take         = in_valid && in_ready;
  assign pend_valid   = slot_full;
  assign pend_payload = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q  <= 1'b0;
      slot_full <= 1'b0;
      samp_q    <= '0;
      slot_q    <= '0;
    end else begin
      if (take) second_q <= !second_q;
      if (take && !second_q) samp_q <= samp_d;
      if (take && second_q) begin
        slot_q    <= {FRM_A1, FRM_A1, FRM_A2, FRM_A2, samp_q};
        slot_full <= 1'b1;
      end else if (pend_ready && slot_full) begin
        slot_full <= 1'b0;
      end
    end
  end

  // R5: a frame only appears after an input unit was taken
  assert_frame_from_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_valid) |-> $past(in_valid && in_ready));
  // R7: a refused unit means a frame is waiting
  assert_refuse_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> pend_valid);
endmodule

// File: rtl/dsk_crc24.sv
module dsk_crc24
  import dsk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             din,
  input  logic             shift,
  output logic             msb
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (init)  crc_q <= CRC_SEED;
    else if (step)  crc_q <= crc_step(crc_q, din);
    else if (shift) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign msb = crc_q[CRC_W-1];

  // R4: update and emit phases never overlap
  assert_step_shift_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && shift));
endmodule

// File: rtl/dsk_serializer.sv
module dsk_serializer
  import dsk_pkg::*;
#(
  parameter int PAY_W = 112,
  localparam int FRAME_W = PAY_W + CRC_W,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_valid,
  output logic             pend_ready,
  input  logic [PAY_W-1:0] pend_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             out_sof
);
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] sh_q;
  logic             xfer, last, in_pay, load, crc_msb;

  assign xfer       = busy && out_ready;
  assign last       = (cnt == CNT_W'(FRAME_W - 1));
  assign in_pay     = (cnt < CNT_W'(PAY_W));
  assign pend_ready = !busy || (xfer && last);
  assign load       = pend_valid && pend_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sh_q <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      sh_q <= pend_payload;
    end else if (xfer) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
      if (in_pay) sh_q <= {sh_q[PAY_W-2:0], 1'b0};
    end
  end

  dsk_crc24 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (load),
    .step  (xfer && in_pay),
    .din   (sh_q[PAY_W-1]),
    .shift (xfer && !in_pay),
    .msb   (crc_msb)
  );

  assign out_valid = busy;
  assign out_bit   = in_pay ? sh_q[PAY_W-1] : crc_msb;
  assign out_sof   = busy && (cnt == '0);

  // R6: a stalled bit is held
  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_sof)));
  // R8: waiting frame follows without a gap
  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && last && pend_valid) |=> (out_valid && out_sof));
  // R1: a start marker follows a completed frame or an idle serializer
  assert_sof_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_sof) |-> $past(!out_valid || (out_ready && last)));
  // R1: bit counter stays inside the frame
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/dsk_refgen.sv
module dsk_refgen
  import dsk_pkg::*;
#(
  parameter int LANES = 10,
  localparam int PAY_W = HDR_W + LANES * SAMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*UNIT_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_bit,
  output logic                    out_sof
);
  logic             pend_valid, pend_ready;
  logic [PAY_W-1:0] pend_payload;

  dsk_sampler #(.LANES(LANES)) u_samp (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .pend_valid   (pend_valid),
    .pend_ready   (pend_ready),
    .pend_payload (pend_payload)
  );

  dsk_serializer #(.PAY_W(PAY_W)) u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_valid   (pend_valid),
    .pend_ready   (pend_ready),
    .pend_payload (pend_payload),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_bit      (out_bit),
    .out_sof      (out_sof)
  );

  // R9: nothing leaves before a frame was assembled
  assert_idle_until_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pend_valid));
endmodule

// File: tb/dsk_refgen_tb.sv
module dsk_refgen_tb;
  localparam int LANES = 10;
  localparam int DW = LANES * 68;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                                       32'hA5C3_0F96, 32'h0BAD_F00D, 32'h8000_0001};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_bit, out_sof;
  int checks = 0, errors = 0;
  longint cyc = 0;
  bit bp_mode = 0;
  int stall_bad = 0;
  bit prev_stall = 0, prev_bit = 0, prev_sof = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsk_refgen #(.LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_sof(out_sof)
  );

  function automatic logic [DW-1:0] mk_unit(input logic [31:0] s, input int k);
    logic [DW-1:0] d;
    for (int n = 0; n < LANES; n++) begin
      logic [7:0] b;
      b = s[7:0] ^ 8'(n * 29) ^ (k != 0 ? 8'hA5 : 8'h00) ^ s[31:24];
      d[n*68 +: 68] = {b, s, 28'(s[27:0] ^ 28'(n * 1117 + k * 77))};
    end
    return d;
  endfunction

  function automatic logic [135:0] exp_frame(input logic [DW-1:0] u);
    logic [135:0] f;
    logic [23:0] c;
    f[135:104] = 32'hF6F6_2828;
    for (int n = 0; n < LANES; n++) f[103 - 8*n -: 8] = u[n*68 + 60 +: 8];
    c = 24'hFFFFFF;
    for (int i = 135; i >= 24; i--) begin
      logic fb;
      fb = c[23] ^ f[i];
      c = {c[22:0], 1'b0};
      if (fb) c = c ^ 24'h864CFB;
    end
    f[23:0] = c;
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_unit(input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1; in_data = d; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic get_frame(output logic [135:0] f, output int sof_bad, output longint c0, output longint c1);
    int k;
    k = 0; sof_bad = 0; f = '0; c0 = 0; c1 = 0;
    while (k < 136) begin
      @(negedge clk);
      if (bp_mode) out_ready = (cyc % 3) != 1;
      #1;
      if (prev_stall && (!out_valid || out_bit != prev_bit || out_sof != prev_sof)) stall_bad++;
      prev_stall = out_valid && !out_ready; prev_bit = out_bit; prev_sof = out_sof;
      if (out_valid && out_ready) begin
        f[135-k] = out_bit;
        if (out_sof != (k == 0)) sof_bad++;
        if (k == 0) c0 = cyc;
        if (k == 135) c1 = cyc;
        k++;
      end
    end
  endtask

  task automatic check_frame(input logic [135:0] act, input logic [135:0] exp, input int sof_bad, input string tag);
    check(act[135:104] == exp[135:104], {"R2 header ", tag}, act, exp);
    check(act[103:24] == exp[103:24], {"R3 samples ", tag}, act, exp);
    check(act[23:0] == exp[23:0], {"R4 crc ", tag}, act, exp);
    check(sof_bad == 0, {"R1 sof ", tag}, 136'(sof_bad), 136'(0));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [135:0] f;
    int sb;
    longint c0, c1, prev_last;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0, "R9 out_valid in reset", 136'(out_valid), 136'(0));
    check(in_ready == 1, "R9 in_ready in reset", 136'(in_ready), 136'(1));
    rst_n = 1;
    @(negedge clk); #1;
    check(out_valid == 0, "R9 out_valid after reset", 136'(out_valid), 136'(0));

    // table walk: back-to-back pairs, second unit differs from the first (R5)
    prev_last = 0;
    fork
      begin
        for (int i = 0; i < NV; i++) begin
          send_unit(mk_unit(VEC[i], 0));
          send_unit(mk_unit(VEC[i], 1));
        end
        @(negedge clk); in_valid = 0;
      end
      begin
        for (int i = 0; i < NV; i++) begin
          get_frame(f, sb, c0, c1);
          check_frame(f, exp_frame(mk_unit(VEC[i], 0)), sb, $sformatf("vec%0d", i));
          if (i > 0) check(c0 == prev_last + 1, "R8 gapless", 136'(c0), 136'(prev_last + 1));
          prev_last = c1;
        end
      end
    join

    // R6: sink back-pressure
    do_reset();
    bp_mode = 1; stall_bad = 0; prev_stall = 0;
    fork
      begin
        send_unit(mk_unit(32'h5A5A_1234, 0));
        send_unit(mk_unit(32'h5A5A_1234, 1));
        @(negedge clk); in_valid = 0;
      end
      get_frame(f, sb, c0, c1);
    join
    bp_mode = 0; out_ready = 1;
    check_frame(f, exp_frame(mk_unit(32'h5A5A_1234, 0)), sb, "backpressure");
    check(stall_bad == 0, "R6 hold under stall", 136'(stall_bad), 136'(0));

    // R7: refusal of a second unit while a frame waits
    do_reset();
    out_ready = 0;
    send_unit(mk_unit(32'h0000_1111, 0));
    send_unit(mk_unit(32'h0000_1111, 1));
    send_unit(mk_unit(32'h0000_2222, 0));
    send_unit(mk_unit(32'h0000_2222, 1));
    @(negedge clk); in_data = mk_unit(32'h0000_3333, 0); #1;
    check(in_ready == 1, "R7 first unit accepted while full", 136'(in_ready), 136'(1));
    @(posedge clk);
    @(negedge clk); in_data = mk_unit(32'h0000_3333, 1); #1;
    check(in_ready == 0, "R7 second unit refused while full", 136'(in_ready), 136'(0));
    repeat (4) @(negedge clk);
    #1;
    check(in_ready == 0, "R7 still refused", 136'(in_ready), 136'(0));
    @(negedge clk); in_valid = 0;

    // R5: reset in the middle of a pair restarts the phase
    do_reset();
    send_unit(mk_unit(32'hDEAD_0001, 0));
    @(negedge clk); in_valid = 0;
    do_reset();
    fork
      begin
        send_unit(mk_unit(32'hCAFE_0002, 0));
        send_unit(mk_unit(32'hCAFE_0002, 1));
        @(negedge clk); in_valid = 0;
      end
      get_frame(f, sb, c0, c1);
    join
    check(f == exp_frame(mk_unit(32'hCAFE_0002, 0)), "R5 pair restarts after reset",
          f, exp_frame(mk_unit(32'hCAFE_0002, 0)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule